// File: doc/BRIEF.md
# Center-Symmetric Census Matching Cost

The block turns rectified stereo pixel windows into per-disparity matching costs. On each accepted beat it receives two 9-by-7 windows of 8-bit grayscale pixels, one centred on a base-image pixel and one centred on the match-image pixel in the same column. An upstream line buffer supplies these windows. For each window the block forms a 31-bit signature. Each bit of the signature compares a pixel with its partner mirrored through the window centre. The match signatures of the current row are kept in a history that is as deep as the disparity range.

After a window pair is accepted, the block emits one cost per disparity level on consecutive cycles, with disparity 0 first. The cost at disparity d is the Hamming distance between the base signature of pixel x and the match signature of pixel x−d. When x−d lies left of the row start, the cost is forced to 31. The input holds off further windows while a pixel's costs are being issued. It reopens in the cycle that issues the last disparity, so back-to-back pixels produce an unbroken cost stream.

Top module: `csc_cost_top`

## Requirements
- R1: Pixel p of a window, where p = row*9 + col in raster order, sits at bits [8p+7:8p] of the window port. Signature bit k (k = 0..30) is 1 exactly when pixel k is strictly greater, as an unsigned value, than pixel 62−k. Equal pixels give 0.
- R2: For an available match pixel, the cost at disparity d equals the number of set bits in (base signature of x) XOR (match signature of x−d). The cost lies in 0..31 and is carried in the 8-bit cost port.
- R3: Every accepted window produces NUM_DISP costs on consecutive cycles, with disp_o stepping 0, 1, ..., NUM_DISP−1.
- R4: When d exceeds the number of windows accepted since the current row began minus one, the match pixel x−d lies left of the image and the cost is 31.
- R5: The cost for disparity d is presented in the cycle that follows the (d+3)-th clock edge after the edge that accepted the window.
- R6: win_ready_o is low in the cycle after an accept and stays low until the cycle that issues the last disparity, where it is high again. A window offered then leads to an output stream with no gap.
- R7: A beat accepted with sol_i high starts a new row. Match signatures from earlier rows are never used, and their disparities are masked as in R4. The first accepted beat after reset carries sol_i.
- R8: During and right after reset, win_ready_o is high and cost_valid_o is low.
- R9: Beats with win_valid_i low have no effect: no costs are produced for them, and they change neither the row history nor the column count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_valid_i | input | 1 | Window pair offered |
| win_ready_o | output | 1 | Window pair can be taken |
| sol_i | input | 1 | Beat is the first pixel of a row |
| base_win_i | input | WIN_W*WIN_H*PIX_W (504) | Base-image window, raster order |
| match_win_i | input | WIN_W*WIN_H*PIX_W (504) | Match-image window, raster order |
| cost_valid_o | output | 1 | Cost output valid |
| cost_o | output | COST_W (8) | Hamming cost |
| disp_o | output | log2(NUM_DISP) (7) | Disparity index of cost_o |

## Verification
The bench targets the row start. It uses rows shorter than the disparity range and rows that follow a long row. A design that counted columns wrongly or kept stale history there would emit real Hamming values where 31 is due. It drives windows with equal mirrored pairs and with strictly ordered pairs, which exposes a swapped or non-strict comparison as a signature of the wrong polarity. It offers windows exactly in the last issue cycle and inserts idle beats with junk data. An off-by-one in the ready logic would then show as gaps or lost pixels, and a history that shifted on invalid beats would produce wrong costs at every later disparity.

// File: rtl/csc_pkg.sv
package csc_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_state_e;

  function automatic int unsigned sig_width(input int unsigned win_w, input int unsigned win_h);
    return (win_w * win_h - 1) / 2;
  endfunction

endpackage

// File: rtl/csc_signature.sv
module csc_signature #(
  parameter int unsigned WIN_W = 9,
  parameter int unsigned WIN_H = 7,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned NPIX = WIN_W * WIN_H,
  localparam int unsigned SIG_W = csc_pkg::sig_width(WIN_W, WIN_H)
) (
  input  logic [NPIX*PIX_W-1:0] win_i,
  output logic [SIG_W-1:0]      sig_o
);

  // bit k: pixel k before the centre against its point reflection
  for (genvar k = 0; k < SIG_W; k++) begin : g_pair
    assign sig_o[k] = win_i[k*PIX_W +: PIX_W] > win_i[(NPIX-1-k)*PIX_W +: PIX_W];
  end

endmodule

// File: rtl/csc_disp_seq.sv
module csc_disp_seq #(
  parameter int unsigned SIG_W    = 31,
  parameter int unsigned NUM_DISP = 128,
  localparam int unsigned DISP_W  = (NUM_DISP > 1) ? $clog2(NUM_DISP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_valid_i,
  output logic              win_ready_o,
  input  logic              sol_i,
  input  logic [SIG_W-1:0]  base_sig_i,
  input  logic [SIG_W-1:0]  match_sig_i,
  output logic              iss_vld_o,
  output logic [SIG_W-1:0]  iss_base_o,
  output logic [SIG_W-1:0]  iss_match_o,
  output logic              iss_mask_o,
  output logic [DISP_W-1:0] iss_disp_o
);
  import csc_pkg::*;

  localparam logic [DISP_W-1:0] LAST_D = DISP_W'(NUM_DISP - 1);

  seq_state_e        state_q;
  logic [DISP_W-1:0] disp_q;
  logic [DISP_W-1:0] col_q;
  logic [SIG_W-1:0]  base_q;
  logic [SIG_W-1:0]  hist_q [NUM_DISP];
  logic              last_iss;
  logic              acc;

  assign last_iss    = (state_q == SEQ_ISSUE) && (disp_q == LAST_D);
  assign win_ready_o = (state_q == SEQ_IDLE) || last_iss;
  assign acc         = win_valid_i && win_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      disp_q  <= '0;
      col_q   <= '0;
      base_q  <= '0;
    end else if (acc) begin
      state_q <= SEQ_ISSUE;
      disp_q  <= '0;
      base_q  <= base_sig_i;
      if (sol_i)               col_q <= '0;
      else if (col_q < LAST_D) col_q <= col_q + 1'b1;
    end else if (last_iss) begin
      state_q <= SEQ_IDLE;
    end else if (state_q == SEQ_ISSUE) begin
      disp_q <= disp_q + 1'b1;
    end
  end

  // match history: entry i holds the signature i columns to the left
  for (genvar i = 0; i < NUM_DISP; i++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  hist_q[i] <= '0;
      else if (acc) hist_q[i] <= (i == 0) ? match_sig_i : hist_q[(i == 0) ? 0 : i-1];
    end
  end

  assign iss_vld_o   = (state_q == SEQ_ISSUE);
  assign iss_base_o  = base_q;
  assign iss_match_o = hist_q[disp_q];
  assign iss_mask_o  = disp_q > col_q;
  assign iss_disp_o  = disp_q;

endmodule

// File: rtl/csc_popcnt_pipe.sv
module csc_popcnt_pipe #(
  parameter int unsigned SIG_W  = 31,
  parameter int unsigned GRP_W  = 8,
  parameter int unsigned COST_W = 8,
  parameter int unsigned DISP_W = 7,
  localparam int unsigned NGRP   = (SIG_W + GRP_W - 1) / GRP_W,
  localparam int unsigned PAD_W  = NGRP * GRP_W,
  localparam int unsigned GCNT_W = $clog2(GRP_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  input  logic [SIG_W-1:0]  in_base_i,
  input  logic [SIG_W-1:0]  in_match_i,
  input  logic              in_mask_i,
  input  logic [DISP_W-1:0] in_disp_i,
  output logic              out_vld_o,
  output logic [COST_W-1:0] out_cost_o,
  output logic [DISP_W-1:0] out_disp_o
);

  logic [PAD_W-1:0]  diff_q;
  logic              vld_a, vld_b, vld_c;
  logic              mask_a, mask_b;
  logic [DISP_W-1:0] disp_a, disp_b, disp_c;
  logic [GCNT_W-1:0] grp_d [NGRP];
  logic [GCNT_W-1:0] grp_q [NGRP];
  logic [COST_W-1:0] tot_d, cost_q;

  // stage a: difference vector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_a  <= 1'b0;
      mask_a <= 1'b0;
      disp_a <= '0;
      diff_q <= '0;
    end else begin
      vld_a  <= in_vld_i;
      mask_a <= in_mask_i;
      disp_a <= in_disp_i;
      diff_q <= PAD_W'(in_base_i ^ in_match_i);
    end
  end

  // stage b: per-group counts
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      grp_d[g] = '0;
      for (int i = 0; i < GRP_W; i++) grp_d[g] = grp_d[g] + GCNT_W'(diff_q[g*GRP_W+i]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) grp_q[g] <= '0;
      else         grp_q[g] <= grp_d[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_b  <= 1'b0;
      mask_b <= 1'b0;
      disp_b <= '0;
    end else begin
      vld_b  <= vld_a;
      mask_b <= mask_a;
      disp_b <= disp_a;
    end
  end

  // stage c: tree root, masked columns saturate
  always_comb begin
    tot_d = '0;
    for (int g = 0; g < NGRP; g++) tot_d = tot_d + COST_W'(grp_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_c  <= 1'b0;
      disp_c <= '0;
      cost_q <= '0;
    end else begin
      vld_c  <= vld_b;
      disp_c <= disp_b;
      cost_q <= mask_b ? COST_W'(SIG_W) : tot_d;
    end
  end

  assign out_vld_o  = vld_c;
  assign out_cost_o = cost_q;
  assign out_disp_o = disp_c;

endmodule

// File: rtl/csc_cost_top.sv
module csc_cost_top #(
  parameter int unsigned WIN_W    = 9,
  parameter int unsigned WIN_H    = 7,
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned NUM_DISP = 128,
  parameter int unsigned COST_W   = 8,
  parameter int unsigned GRP_W    = 8,
  localparam int unsigned WIN_BITS = WIN_W * WIN_H * PIX_W,
  localparam int unsigned SIG_W    = csc_pkg::sig_width(WIN_W, WIN_H),
  localparam int unsigned DISP_W   = (NUM_DISP > 1) ? $clog2(NUM_DISP) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                win_valid_i,
  output logic                win_ready_o,
  input  logic                sol_i,
  input  logic [WIN_BITS-1:0] base_win_i,
  input  logic [WIN_BITS-1:0] match_win_i,
  output logic                cost_valid_o,
  output logic [COST_W-1:0]   cost_o,
  output logic [DISP_W-1:0]   disp_o
);

  logic [SIG_W-1:0]  base_sig, match_sig;
  logic              iss_vld, iss_mask;
  logic [SIG_W-1:0]  iss_base, iss_match;
  logic [DISP_W-1:0] iss_disp;

  csc_signature #(.WIN_W(WIN_W), .WIN_H(WIN_H), .PIX_W(PIX_W)) i_sig_base (
    .win_i (base_win_i),
    .sig_o (base_sig)
  );

  csc_signature #(.WIN_W(WIN_W), .WIN_H(WIN_H), .PIX_W(PIX_W)) i_sig_match (
    .win_i (match_win_i),
    .sig_o (match_sig)
  );

  csc_disp_seq #(.SIG_W(SIG_W), .NUM_DISP(NUM_DISP)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_valid_i (win_valid_i),
    .win_ready_o (win_ready_o),
    .sol_i       (sol_i),
    .base_sig_i  (base_sig),
    .match_sig_i (match_sig),
    .iss_vld_o   (iss_vld),
    .iss_base_o  (iss_base),
    .iss_match_o (iss_match),
    .iss_mask_o  (iss_mask),
    .iss_disp_o  (iss_disp)
  );

  csc_popcnt_pipe #(.SIG_W(SIG_W), .GRP_W(GRP_W), .COST_W(COST_W), .DISP_W(DISP_W)) i_pop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_vld_i   (iss_vld),
    .in_base_i  (iss_base),
    .in_match_i (iss_match),
    .in_mask_i  (iss_mask),
    .in_disp_i  (iss_disp),
    .out_vld_o  (cost_valid_o),
    .out_cost_o (cost_o),
    .out_disp_o (disp_o)
  );

endmodule

// File: rtl/csc_cost_chk.sv
module csc_cost_chk #(
  parameter int unsigned SIG_W    = 31,
  parameter int unsigned NUM_DISP = 128,
  parameter int unsigned COST_W   = 8,
  parameter int unsigned DISP_W   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              win_valid_i,
  input logic              win_ready_o,
  input logic              cost_valid_o,
  input logic [COST_W-1:0] cost_o,
  input logic [DISP_W-1:0] disp_o
);

  a_r2_cost_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cost_valid_o |-> (cost_o <= COST_W'(SIG_W)));

  a_r3_disp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cost_valid_o && disp_o != '0) |-> ($past(cost_valid_o) && disp_o == DISP_W'($past(disp_o) + 1'b1)));

  a_r5_first_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_i && win_ready_o) |-> ##4 (cost_valid_o && disp_o == '0));

  a_r6_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_i && win_ready_o && NUM_DISP > 1) |=> !win_ready_o);

  a_r8_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (win_ready_o && !cost_valid_o));

endmodule

bind csc_cost_top csc_cost_chk #(
  .SIG_W(SIG_W), .NUM_DISP(NUM_DISP), .COST_W(COST_W), .DISP_W(DISP_W)
) i_csc_cost_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .win_valid_i  (win_valid_i),
  .win_ready_o  (win_ready_o),
  .cost_valid_o (cost_valid_o),
  .cost_o       (cost_o),
  .disp_o       (disp_o)
);

// File: tb/test_csc_cost_top.sv
module test_csc_cost_top;

  localparam int ND   = 8;
  localparam int DW   = 3;
  localparam int WB   = 504;
  localparam int NB   = 40;

  typedef struct {
    int    cyc;
    int    cost;
    int    disp;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          win_valid_i = 1'b0;
  logic          win_ready_o;
  logic          sol_i = 1'b0;
  logic [WB-1:0] base_win_i = '0;
  logic [WB-1:0] match_win_i = '0;
  logic          cost_valid_o;
  logic [7:0]    cost_o;
  logic [DW-1:0] disp_o;

  csc_cost_top #(.NUM_DISP(ND)) i_csc_cost_top (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .win_valid_i  (win_valid_i),
    .win_ready_o  (win_ready_o),
    .sol_i        (sol_i),
    .base_win_i   (base_win_i),
    .match_win_i  (match_win_i),
    .cost_valid_o (cost_valid_o),
    .cost_o       (cost_o),
    .disp_o       (disp_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int bi     = 0;
  bit done   = 0;
  bit prev_acc = 0;
  int tail   = 0;

  logic          bv [NB];
  logic          bs [NB];
  logic [WB-1:0] bb [NB];
  logic [WB-1:0] bm [NB];

  exp_t       eq [$];
  bit [30:0]  mh [$];

  function automatic bit [30:0] csig(input logic [WB-1:0] w);
    bit [30:0] s;
    for (int k = 0; k < 31; k++) s[k] = w[k*8 +: 8] > w[(62-k)*8 +: 8];
    return s;
  endfunction

  function automatic logic [WB-1:0] flat_win(input int v);
    logic [WB-1:0] w;
    for (int p = 0; p < 63; p++) w[p*8 +: 8] = 8'(v);
    return w;
  endfunction

  function automatic logic [WB-1:0] desc_win();
    logic [WB-1:0] w;
    for (int p = 0; p < 63; p++) w[p*8 +: 8] = 8'(200 - p);
    return w;
  endfunction

  function automatic logic [WB-1:0] rnd_win();
    logic [WB-1:0] w;
    for (int p = 0; p < 63; p++) w[p*8 +: 8] = 8'($urandom_range(0, 255));
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_push(input int c);
    bit [30:0] bsig;
    bsig = csig(bb[bi]);
    if (bs[bi]) mh.delete();
    mh.push_front(csig(bm[bi]));
    if (mh.size() > ND) void'(mh.pop_back());
    for (int d = 0; d < ND; d++) begin
      exp_t e;
      e.cyc  = c + 4 + d;
      e.disp = d;
      if (d < mh.size()) begin
        e.cost = $countones(bsig ^ mh[d]);
        e.tag  = (d == 0) ? "R1/R2" : "R2/R3";
      end else begin
        e.cost = 31;
        e.tag  = "R4/R7";
      end
      eq.push_back(e);
    end
  endtask

  // stimulus: three rows, idle beats in between (R9)
  initial begin
    for (int i = 0; i < NB; i++) begin
      bv[i] = 1'b1;
      bs[i] = 1'b0;
      bb[i] = rnd_win();
      bm[i] = rnd_win();
    end
    bs[0] = 1'b1; bb[0] = desc_win();   bm[0] = flat_win(50);   // 31 at d0
    bb[1] = flat_win(77); bm[1] = flat_win(9);                  // equal pairs -> 0
    bb[2] = desc_win();   bm[2] = desc_win();                   // 0 at d0
    bv[4] = 1'b0; bs[4] = 1'b1;                                 // ignored junk
    bv[5] = 1'b0;
    bs[16] = 1'b1;                                              // short row after long
    bv[18] = 1'b0; bs[18] = 1'b1;
    bs[21] = 1'b1;
    bv[30] = 1'b0;
    bv[31] = 1'b0; bs[31] = 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      chk(win_ready_o === 1'b1, "R8", win_ready_o, 1);
      chk(cost_valid_o === 1'b0, "R8", cost_valid_o, 0);
    end else if (!done) begin
      bit exp_v;
      cyc++;
      exp_v = (eq.size() > 0) && (eq[0].cyc == cyc);
      chk(cost_valid_o === exp_v, "R5/R3/R9 valid", cost_valid_o, exp_v);
      if (exp_v) begin
        chk(cost_o === 8'(eq[0].cost), eq[0].tag, cost_o, eq[0].cost);
        chk(disp_o === DW'(eq[0].disp), "R3 disp", disp_o, eq[0].disp);
        void'(eq.pop_front());
      end
      if (prev_acc) chk(win_ready_o === 1'b0, "R6 hold", win_ready_o, 0);
      if (bi < NB && cyc > 1 && (prev_acc || !bv[bi])) bi++;
      if (bi < NB) begin
        win_valid_i = bv[bi];
        sol_i       = bs[bi];
        base_win_i  = bb[bi];
        match_win_i = bm[bi];
      end else begin
        win_valid_i = 1'b0;
        sol_i       = 1'b1;
        base_win_i  = rnd_win();
        match_win_i = rnd_win();
      end
      prev_acc = (bi < NB) && win_valid_i && win_ready_o;
      if (prev_acc) model_push(cyc);
      if (bi >= NB && eq.size() == 0) tail++;
      if (tail > 6) done = 1;
      if (cyc > 5000) begin
        chk(1'b0, "watchdog", cyc, 5000);
        done = 1;
      end
      if (done) begin
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_ni = 1'b1;
  end

endmodule